// File: doc/BRIEF.md
# Interrupt Event Run-Length Logger

This block records, for one serial-bus transaction, the sequence of interrupt events that the bus controller raises. Each event arrives on a valid/ready stream with the active interrupt bit pattern and the number of bytes moved into the transmit FIFO and out of the receive FIFO while that event was serviced. An event starts a new log row unless its pattern equals the pattern of the newest row. In that case the newest row absorbs it: its repeat count goes up by one and its byte totals grow. Each row also carries the value of a free-running tick counter, taken when the row was opened.

A one-cycle `txn_start` pulse empties the log at the start of every transaction. The tick counter is not reset by it. Software or a debug path reads rows back through a plain indexed port. The row comes out one cycle after the request, together with the current number of valid rows. The log holds a fixed number of rows. When it is full, events that would need a new row are thrown away, and a sticky flag records that this happened.

Back-pressure rules: an event is taken on a clock edge where `evt_valid` and `evt_ready` are both high. `evt_ready` is low only in a cycle where `txn_start` is high. A producer that sees it low keeps its event stable and offers it again in the next cycle. `evt_valid` may be high in any cycle. The read port has no handshake.

Top module: `irq_runlog`

## Requirements
- R1: After reset `row_count` is 0, `overflow` is 0 and `rd_valid` is 0.
- R2: A taken event whose pattern differs from the newest row, or that arrives when the log is empty, opens row `row_count` with pattern = `evt_irq`, count = 1, tx total = `evt_tx`, rx total = `evt_rx`, stamp = current tick counter. `row_count` then grows by 1.
- R3: A taken event whose pattern equals the newest row's pattern updates that row: count + 1, tx total + `evt_tx`, rx total + `evt_rx`. The row's pattern and stamp stay as they were, and `row_count` does not change.
- R4: The repeat count saturates at 2^CNT_W-1 (default 16 bits) and never wraps.
- R5: The tx and rx totals each saturate at 2^TOT_W-1 and never wrap.
- R6: The tick counter starts at 0 after reset. It advances by 1 on each clock edge where `tick` is high. A row's stamp is the counter value in the cycle the opening event is taken, which is the number of tick edges before that one.
- R7: With `row_count` = DEPTH, an event that would open a row is dropped and `overflow` becomes 1. An event that matches the newest row still merges into it.
- R8: A cycle with `txn_start` high sets `row_count` to 0 and `overflow` to 0. `evt_ready` is low in that cycle, so any event offered then is not taken. The tick counter keeps running, and the next event always opens row 0.
- R9: An `rd_en` pulse with `rd_idx` < `row_count` gives `rd_valid` = 1 one cycle later, with that row's fields on `rd_irq`, `rd_count`, `rd_tx`, `rd_rx` and `rd_time`. An index ≥ `row_count` gives `rd_valid` = 0.
- R10: A cycle with `evt_valid` low changes no row and neither `row_count` nor `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | Empties the log and clears overflow |
| tick | input | 1 | Advances the timestamp counter |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event can be taken |
| evt_irq | input | IRQ_W | Active interrupt bit pattern |
| evt_tx | input | BYTE_W | Bytes pushed into the transmit FIFO for this event |
| evt_rx | input | BYTE_W | Bytes pulled from the receive FIFO for this event |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Row index to read |
| rd_valid | output | 1 | Read data valid (index was in range) |
| rd_irq | output | IRQ_W | Row pattern |
| rd_count | output | CNT_W | Row repeat count |
| rd_tx | output | TOT_W | Row transmit byte total |
| rd_rx | output | TOT_W | Row receive byte total |
| rd_time | output | TS_W | Row opening timestamp |
| row_count | output | FILL_W | Number of valid rows |
| overflow | output | 1 | Sticky: an event was dropped because the log was full |

## Verification
The bench compares an event against the newest row only, so the pattern A, C, A must open three rows. A design that searched every row would merge the second A into row 0. Long runs of one pattern push the count and the byte totals past their limits; a design without saturation would wrap them to small values. The full log is tested with both a new pattern and a repeat of the newest pattern. A wrong design either writes past the last row or refuses the repeat. An event offered in the same cycle as `txn_start` must be lost. After the clear, an event equal to the last pattern from before the clear must open row 0; a design that keeps the old pattern would merge it into a row that no longer exists.

// File: rtl/irq_runlog_pkg.sv
package irq_runlog_pkg;

  // What the controller does with the event offered in the current cycle.
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_OPEN  = 2'd1,
    ACT_MERGE = 2'd2,
    ACT_DROP  = 2'd3
  } row_act_e;

endpackage

// File: rtl/irq_runlog_tstamp.sv
module irq_runlog_tstamp #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic [TS_W-1:0] ts
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ts <= '0;
    else if (tick) ts <= ts + 1'b1;
  end

  AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ts)); // R6

endmodule

// File: rtl/irq_runlog_ctrl.sv
module irq_runlog_ctrl
  import irq_runlog_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int IRQ_W  = 16,
  parameter int IDX_W  = 5,
  parameter int FILL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic              evt_valid,
  input  logic [IRQ_W-1:0]  evt_irq,
  output logic              evt_ready,
  output row_act_e          act,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [FILL_W-1:0] fill,
  output logic              overflow
);

  logic [IRQ_W-1:0] last_irq;
  logic             take;
  logic             same;
  logic             room;

  assign evt_ready = !txn_start;
  assign take      = evt_valid && evt_ready;
  assign same      = (fill != '0) && (evt_irq == last_irq);
  assign room      = fill < FILL_W'(DEPTH);

  always_comb begin
    act = ACT_IDLE;
    if (take) begin
      if (same)      act = ACT_MERGE;
      else if (room) act = ACT_OPEN;
      else           act = ACT_DROP;
    end
  end

  assign wr_idx = same ? IDX_W'(fill - 1'b1) : IDX_W'(fill);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill     <= '0;
      overflow <= 1'b0;
      last_irq <= '0;
    end else if (txn_start) begin
      fill     <= '0;
      overflow <= 1'b0;
    end else begin
      case (act)
        ACT_OPEN: begin
          fill     <= fill + 1'b1;
          last_irq <= evt_irq;
        end
        ACT_DROP: overflow <= 1'b1;
        default: ;
      endcase
    end
  end

  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(DEPTH)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !txn_start |=> overflow); // R7
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |=> (fill == '0) && !overflow); // R8
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_start |=> (fill == $past(fill)) || (fill == $past(fill) + 1'b1)); // R2
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid && !txn_start |=> $stable(fill) && $stable(overflow)); // R10

endmodule

// File: rtl/irq_runlog_rows.sv
module irq_runlog_rows
  import irq_runlog_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int IRQ_W  = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16,
  parameter int TOT_W  = 16,
  parameter int TS_W   = 32,
  parameter int IDX_W  = 5,
  parameter int FILL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  row_act_e          act,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IRQ_W-1:0]  evt_irq,
  input  logic [BYTE_W-1:0] evt_tx,
  input  logic [BYTE_W-1:0] evt_rx,
  input  logic [TS_W-1:0]   ts,
  input  logic [FILL_W-1:0] fill,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [IRQ_W-1:0]  rd_irq,
  output logic [CNT_W-1:0]  rd_count,
  output logic [TOT_W-1:0]  rd_tx,
  output logic [TOT_W-1:0]  rd_rx,
  output logic [TS_W-1:0]   rd_time
);

  logic [IRQ_W-1:0] r_irq [DEPTH];
  logic [CNT_W-1:0] r_cnt [DEPTH];
  logic [TOT_W-1:0] r_tx  [DEPTH];
  logic [TOT_W-1:0] r_rx  [DEPTH];
  logic [TS_W-1:0]  r_ts  [DEPTH];

  // Merge arithmetic is computed once, against the addressed row.
  logic [CNT_W-1:0] tail_cnt, cnt_next;
  logic [TOT_W:0]   tx_sum, rx_sum;
  logic [TOT_W-1:0] tx_next, rx_next;

  assign tail_cnt = r_cnt[wr_idx];
  assign cnt_next = (&tail_cnt) ? tail_cnt : tail_cnt + 1'b1;
  assign tx_sum   = {1'b0, r_tx[wr_idx]} + (TOT_W+1)'(evt_tx);
  assign rx_sum   = {1'b0, r_rx[wr_idx]} + (TOT_W+1)'(evt_rx);
  assign tx_next  = tx_sum[TOT_W] ? '1 : tx_sum[TOT_W-1:0];
  assign rx_next  = rx_sum[TOT_W] ? '1 : rx_sum[TOT_W-1:0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic hit;
    assign hit = (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_irq[i] <= '0;
        r_cnt[i] <= '0;
        r_tx[i]  <= '0;
        r_rx[i]  <= '0;
        r_ts[i]  <= '0;
      end else if (hit && act == ACT_OPEN) begin
        r_irq[i] <= evt_irq;
        r_cnt[i] <= CNT_W'(1);
        r_tx[i]  <= TOT_W'(evt_tx);
        r_rx[i]  <= TOT_W'(evt_rx);
        r_ts[i]  <= ts;
      end else if (hit && act == ACT_MERGE) begin
        r_cnt[i] <= cnt_next;
        r_tx[i]  <= tx_next;
        r_rx[i]  <= rx_next;
      end
    end
  end

  logic rd_hit;
  assign rd_hit = rd_en && (FILL_W'(rd_idx) < fill);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_irq   <= '0;
      rd_count <= '0;
      rd_tx    <= '0;
      rd_rx    <= '0;
      rd_time  <= '0;
    end else begin
      rd_valid <= rd_hit;
      if (rd_hit) begin
        rd_irq   <= r_irq[rd_idx];
        rd_count <= r_cnt[rd_idx];
        rd_tx    <= r_tx[rd_idx];
        rd_rx    <= r_rx[rd_idx];
        rd_time  <= r_ts[rd_idx];
      end
    end
  end

  AST_RD_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_count != '0); // R2
  AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (FILL_W'(rd_idx) >= fill) |=> !rd_valid); // R9
  AST_MERGE_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_MERGE |-> cnt_next >= tail_cnt); // R4

endmodule

// File: rtl/irq_runlog.sv
module irq_runlog
  import irq_runlog_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int IRQ_W  = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16,
  parameter int TOT_W  = 16,
  parameter int TS_W   = 32,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic              tick,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [IRQ_W-1:0]  evt_irq,
  input  logic [BYTE_W-1:0] evt_tx,
  input  logic [BYTE_W-1:0] evt_rx,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [IRQ_W-1:0]  rd_irq,
  output logic [CNT_W-1:0]  rd_count,
  output logic [TOT_W-1:0]  rd_tx,
  output logic [TOT_W-1:0]  rd_rx,
  output logic [TS_W-1:0]   rd_time,
  output logic [FILL_W-1:0] row_count,
  output logic              overflow
);

  row_act_e         act;
  logic [IDX_W-1:0] wr_idx;
  logic [TS_W-1:0]  ts;

  irq_runlog_tstamp #(.TS_W(TS_W)) i_tstamp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ts(ts)
  );

  irq_runlog_ctrl #(
    .DEPTH(DEPTH), .IRQ_W(IRQ_W), .IDX_W(IDX_W), .FILL_W(FILL_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .evt_valid(evt_valid),
    .evt_irq(evt_irq), .evt_ready(evt_ready), .act(act), .wr_idx(wr_idx),
    .fill(row_count), .overflow(overflow)
  );

  irq_runlog_rows #(
    .DEPTH(DEPTH), .IRQ_W(IRQ_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W),
    .TOT_W(TOT_W), .TS_W(TS_W), .IDX_W(IDX_W), .FILL_W(FILL_W)
  ) i_rows (
    .clk(clk), .rst_n(rst_n), .act(act), .wr_idx(wr_idx),
    .evt_irq(evt_irq), .evt_tx(evt_tx), .evt_rx(evt_rx), .ts(ts),
    .fill(row_count), .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid),
    .rd_irq(rd_irq), .rd_count(rd_count), .rd_tx(rd_tx), .rd_rx(rd_rx),
    .rd_time(rd_time)
  );

  AST_NOT_READY_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |-> !evt_ready); // R8

endmodule

// File: tb/test_irq_runlog.sv
module test_irq_runlog;
  localparam int CLK_P  = 10;
  localparam int DEPTH  = 8;
  localparam int IRQ_W  = 16;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam int TOT_W  = 8;
  localparam int TS_W   = 32;
  localparam int IDX_W  = 3;
  localparam int FILL_W = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int TMAX   = (1 << TOT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txn_start = 0, tick = 0, evt_valid = 0, rd_en = 0;
  logic [IRQ_W-1:0] evt_irq = '0;
  logic [BYTE_W-1:0] evt_tx = '0, evt_rx = '0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic evt_ready, rd_valid, overflow;
  logic [IRQ_W-1:0] rd_irq;
  logic [CNT_W-1:0] rd_count;
  logic [TOT_W-1:0] rd_tx, rd_rx;
  logic [TS_W-1:0] rd_time;
  logic [FILL_W-1:0] row_count;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_runlog #(.DEPTH(DEPTH), .IRQ_W(IRQ_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W),
               .TOT_W(TOT_W), .TS_W(TS_W)) i_irq_runlog (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .tick(tick),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_irq(evt_irq),
    .evt_tx(evt_tx), .evt_rx(evt_rx), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_irq(rd_irq), .rd_count(rd_count), .rd_tx(rd_tx),
    .rd_rx(rd_rx), .rd_time(rd_time), .row_count(row_count), .overflow(overflow)
  );

  // Reference model of the log.
  int m_irq[DEPTH], m_cnt[DEPTH], m_tx[DEPTH], m_rx[DEPTH], m_ts[DEPTH];
  int m_fill = 0, m_ticks = 0;
  bit m_ovf = 0;

  // Scoreboard queues, one entry per read issued.
  bit    q_v[$];
  int    q_irq[$], q_cnt[$], q_tx[$], q_rx[$], q_ts[$];
  string q_tag[$];
  logic  issued = 1'b0;

  function automatic int sat(input int v, input int mx);
    return (v > mx) ? mx : v;
  endfunction

  task automatic step(input bit v, input int irq, input int tx, input int rx,
                      input bit tk, input bit st, input bit re, input int ridx,
                      input string tag);
    @(negedge clk);
    evt_valid = v; evt_irq = IRQ_W'(irq); evt_tx = BYTE_W'(tx); evt_rx = BYTE_W'(rx);
    tick = tk; txn_start = st; rd_en = re; rd_idx = IDX_W'(ridx);
    if (re) begin
      bit ok = (ridx < m_fill);
      q_v.push_back(ok); q_tag.push_back(tag);
      q_irq.push_back(ok ? m_irq[ridx] : 0); q_cnt.push_back(ok ? m_cnt[ridx] : 0);
      q_tx.push_back(ok ? m_tx[ridx] : 0);   q_rx.push_back(ok ? m_rx[ridx] : 0);
      q_ts.push_back(ok ? m_ts[ridx] : 0);
    end
    @(posedge clk);
    if (st) begin
      m_fill = 0; m_ovf = 0;
    end else if (v) begin
      if (m_fill > 0 && m_irq[m_fill-1] == irq) begin
        m_cnt[m_fill-1] = sat(m_cnt[m_fill-1] + 1, CMAX);
        m_tx[m_fill-1]  = sat(m_tx[m_fill-1] + tx, TMAX);
        m_rx[m_fill-1]  = sat(m_rx[m_fill-1] + rx, TMAX);
      end else if (m_fill < DEPTH) begin
        m_irq[m_fill] = irq; m_cnt[m_fill] = 1; m_tx[m_fill] = tx;
        m_rx[m_fill] = rx;   m_ts[m_fill] = m_ticks;
        m_fill++;
      end else m_ovf = 1;
    end
    if (tk) m_ticks++;
  endtask

  task automatic evt(input int irq, input int tx, input int rx, input bit tk);
    step(1, irq, tx, rx, tk, 0, 0, 0, "");
  endtask

  task automatic idle(input bit tk);
    step(0, 0, 0, 0, tk, 0, 0, 0, "");
  endtask

  task automatic rd(input int idx, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, idx, tag);
  endtask

  task automatic check_state(input string tag);
    #(CLK_P/4);
    checks++;
    if (row_count !== FILL_W'(m_fill) || overflow !== m_ovf) begin
      fails++;
      $display("FAIL %s: row_count=%0d overflow=%0b expected row_count=%0d overflow=%0b",
               tag, row_count, overflow, m_fill, m_ovf);
    end
  endtask

  // Monitor: compares read results against the scoreboard.
  always @(posedge clk) issued <= rd_en;
  always @(negedge clk) begin
    if (issued && q_v.size() > 0) begin
      bit v; int ei, ec, et, er, es; string tg;
      v = q_v.pop_front(); ei = q_irq.pop_front(); ec = q_cnt.pop_front();
      et = q_tx.pop_front(); er = q_rx.pop_front(); es = q_ts.pop_front();
      tg = q_tag.pop_front();
      checks++;
      if (rd_valid !== v ||
          (v && (rd_irq !== IRQ_W'(ei) || rd_count !== CNT_W'(ec) ||
                 rd_tx !== TOT_W'(et) || rd_rx !== TOT_W'(er) || rd_time !== TS_W'(es)))) begin
        fails++;
        $display("FAIL %s: got v=%0b irq=%h cnt=%0d tx=%0d rx=%0d ts=%0d expected v=%0b irq=%h cnt=%0d tx=%0d rx=%0d ts=%0d",
                 tg, rd_valid, rd_irq, rd_count, rd_tx, rd_rx, rd_time, v, ei, ec, et, er, es);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    #(CLK_P/4);
    checks++;
    if (row_count !== '0 || overflow !== 1'b0 || rd_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: row_count=%0d overflow=%0b rd_valid=%0b expected 0 0 0",
               row_count, overflow, rd_valid);
    end
    // R2 / R6: distinct patterns open rows, some with ticks
    evt(16'h0001, 2, 3, 1);
    idle(1); idle(1);
    evt(16'h0200, 0, 0, 0);
    evt(16'h0080, 0, 8, 1);
    evt(16'h0001, 1, 0, 0);       // matches an older row but not the newest: new row
    check_state("R2 four rows opened");
    rd(0, "R2 row0"); rd(1, "R6 row1 stamp"); rd(2, "R2 row2"); rd(3, "R2 row3 A-C-A");
    rd(5, "R9 index beyond row_count");
    // R3 merge
    evt(16'h0001, 4, 5, 1);
    evt(16'h0001, 1, 1, 0);
    check_state("R3 merge keeps row_count");
    rd(3, "R3 merged row");
    // R10 valid low
    step(0, 16'h7777, 9, 9, 1, 0, 0, 0, "");
    check_state("R10 valid low no change");
    rd(3, "R10 row untouched");
    // R4 / R5 saturation
    evt(16'h0400, 200, 100, 0);
    for (int k = 0; k < 20; k++) evt(16'h0400, 20, 10, k[0]);
    rd(4, "R4 R5 saturated row");
    // R7 fill, drop, merge while full
    evt(16'h0010, 1, 1, 0); evt(16'h0020, 1, 1, 1); evt(16'h0040, 1, 1, 0);
    check_state("R7 full");
    evt(16'h0800, 1, 1, 0);
    check_state("R7 drop sets overflow");
    evt(16'h0040, 3, 2, 0);
    check_state("R7 merge while full");
    rd(7, "R7 last row merged");
    idle(0);
    check_state("R7 overflow sticky");
    // R8 clear with an event offered the same cycle
    step(1, 16'h0040, 5, 5, 1, 1, 0, 0, "");
    check_state("R8 clear");
    rd(0, "R8 no rows after clear");
    evt(16'h0040, 6, 7, 0);
    check_state("R8 first event after clear");
    rd(0, "R8 R6 row0 after clear");
    idle(0); idle(0);
    done = 1;
    finish_run();
  end
endmodule